// File: doc/BRIEF.md
# Unlock Sequence Detector for Nonvolatile Transfers

This block watches the read and write accesses that a host makes to a byte-wide memory and looks for a fixed, ordered run of six read addresses. The run asks the memory controller to copy the SRAM contents into nonvolatile storage (store) or to copy the nonvolatile contents back into the SRAM (recall). The first five addresses are common to both requests. The sixth address picks which transfer is wanted. When a complete run is seen, the block raises a one-clock pulse on the matching output. The controller then carries out the transfer. While it does, the controller holds `busy` high, and the detector counts no accesses during that time.

An access is framed by the active-low chip enable. The block samples the address in every clock in which chip enable is low and keeps the last sample. It also records whether write enable was low in any of those clocks. The access is judged in the clock in which chip enable is first sampled high again. Output enable plays no part, so the block has no port for it. A read of any address that is not the next one expected, or any write at all, throws away the progress made so far. An exception applies when the rejected read is the first key address: that read is taken as step one of a new run.

Top module: `seq_unlock_detect`

## Requirements
- R1: After reset, both pulse outputs are low and the match state is empty, so the first read counted is step one of the run.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, in that order, produce a `storePulse` that lasts exactly one clock. The pulse is visible in the clock that follows the edge at which chip enable is first sampled high after the sixth read.
- R3: The same five reads followed by a read of 0x0F0E produce a one-clock `recallPulse` with the same timing as R2, and `storePulse` stays low.
- R4: When the sixth read is any address other than the two final keys, no pulse is produced and the match returns to empty. A later lone read of 0x0F0F then produces nothing.
- R5: A read of an unexpected address in the middle of the run aborts it. The rest of the sequence that follows produces no pulse.
- R6: An access in which write enable (`writeEnN`) is sampled low in any clock while chip enable is low counts as a write. A write aborts the run, even when its address is the expected one, and a write can never complete the run.
- R7: A read of 0x0000 that breaks a partial run restarts matching at step one. The five remaining reads of a full run then produce a pulse.
- R8: An access that ends while `busy` is high neither advances nor aborts the run and never produces a pulse.
- R9: `storePulse` and `recallPulse` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Active-low chip enable; a low-to-high change ends an access |
| writeEnN | input | 1 | Active-low write enable |
| addr | input | 13 | Access address |
| busy | input | 1 | High while the controller performs a transfer |
| storePulse | output | 1 | One-clock request to copy SRAM into nonvolatile storage |
| recallPulse | output | 1 | One-clock request to copy nonvolatile storage into SRAM |

## Verification
The only results of the block are the two pulses. Each pulse is due one clock after the edge at which chip enable is first sampled high, and it is gone one clock later. The bench drives inputs on the falling edge and holds chip enable low for one rising edge per access. It then raises chip enable and samples both pulses on the next falling edge, which is exactly the cycle in which a completed run must show. For the store run it also samples the following falling edge, to check that the pulse has dropped. Aborts and busy periods are judged by completing the rest of a run and checking that no pulse shows where one would otherwise be due.

// File: rtl/sud_pkg.sv
package sud_pkg;

  localparam int ADDR_W   = 13;
  localparam int KEY_LEN  = 6;
  localparam int STEP_W   = $clog2(KEY_LEN);
  localparam int LAST_IDX = KEY_LEN - 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t LAST_STEP  = step_t'(LAST_IDX);
  localparam addr_t STORE_KEY  = addr_t'(13'h0F0F);
  localparam addr_t RECALL_KEY = addr_t'(13'h0F0E);

  // Shared leading keys, indexed by match step
  function automatic addr_t leadKey(step_t idx);
    case (idx)
      step_t'(0): leadKey = addr_t'(13'h0000);
      step_t'(1): leadKey = addr_t'(13'h1555);
      step_t'(2): leadKey = addr_t'(13'h0AAA);
      step_t'(3): leadKey = addr_t'(13'h1FFF);
      step_t'(4): leadKey = addr_t'(13'h10F0);
      default:    leadKey = addr_t'(13'h0000);
    endcase
  endfunction

  // Datapath to control
  typedef struct packed {
    logic accessDone;
    logic wasWrite;
    logic hitStep;
    logic hitFirst;
    logic hitStore;
    logic hitRecall;
    logic atLast;
  } sudStatus_t;

  // Control to datapath
  typedef struct packed {
    logic advance;
    logic restart;
    logic clear;
    logic fireStore;
    logic fireRecall;
  } sudStrobe_t;

endpackage

// File: rtl/sud_datapath.sv
module sud_datapath
  import sud_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       writeEnN,
  input  addr_t      addr,
  input  sudStrobe_t strobe,
  output sudStatus_t status,
  output step_t      stepQ,
  output logic       storePulse,
  output logic       recallPulse
);

  logic  ceNPrev;
  addr_t capAddr;
  logic  wrSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceNPrev     <= 1'b1;
      capAddr     <= '0;
      wrSeen      <= 1'b0;
      stepQ       <= '0;
      storePulse  <= 1'b0;
      recallPulse <= 1'b0;
    end else begin
      ceNPrev <= chipEnN;
      if (!chipEnN) begin
        capAddr <= addr;
        // first low clock of an access starts a fresh write record
        wrSeen  <= (ceNPrev ? 1'b0 : wrSeen) | ~writeEnN;
      end
      if (strobe.clear)
        stepQ <= '0;
      else if (strobe.restart)
        stepQ <= step_t'(1);
      else if (strobe.advance)
        stepQ <= stepQ + step_t'(1);
      storePulse  <= strobe.fireStore;
      recallPulse <= strobe.fireRecall;
    end
  end

  always_comb begin
    status.accessDone = chipEnN & ~ceNPrev;
    status.wasWrite   = wrSeen;
    status.hitStep    = (capAddr == leadKey(stepQ));
    status.hitFirst   = (capAddr == leadKey(step_t'(0)));
    status.hitStore   = (capAddr == STORE_KEY);
    status.hitRecall  = (capAddr == RECALL_KEY);
    status.atLast     = (stepQ == LAST_STEP);
  end

endmodule

// File: rtl/sud_control.sv
module sud_control
  import sud_pkg::*;
(
  input  logic       busy,
  input  sudStatus_t status,
  output sudStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (status.accessDone && !busy) begin
      if (status.wasWrite) begin
        strobe.clear = 1'b1;
      end else if (status.atLast) begin
        if (status.hitStore) begin
          strobe.fireStore = 1'b1;
          strobe.clear     = 1'b1;
        end else if (status.hitRecall) begin
          strobe.fireRecall = 1'b1;
          strobe.clear      = 1'b1;
        end else if (status.hitFirst) begin
          strobe.restart = 1'b1;
        end else begin
          strobe.clear = 1'b1;
        end
      end else if (status.hitStep) begin
        strobe.advance = 1'b1;
      end else if (status.hitFirst) begin
        strobe.restart = 1'b1;
      end else begin
        strobe.clear = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seq_unlock_detect.sv
module seq_unlock_detect
  import sud_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              writeEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              storePulse,
  output logic              recallPulse
);

  sudStatus_t status;
  sudStrobe_t strobe;
  step_t      stepQ;

  sud_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chipEnN    (chipEnN),
    .writeEnN   (writeEnN),
    .addr       (addr),
    .strobe     (strobe),
    .status     (status),
    .stepQ      (stepQ),
    .storePulse (storePulse),
    .recallPulse(recallPulse)
  );

  sud_control u_ctl (
    .busy  (busy),
    .status(status),
    .strobe(strobe)
  );

endmodule

// File: rtl/sud_checker.sv
module sud_checker
  import sud_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  chipEnN,
  input logic  busy,
  input logic  storePulse,
  input logic  recallPulse,
  input step_t stepQ
);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(storePulse && recallPulse));

  assert_store_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    storePulse |=> !storePulse);

  assert_recall_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    recallPulse |=> !recallPulse);

  assert_pulse_at_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (storePulse || recallPulse) |-> ($past(chipEnN) && !$past(chipEnN, 2)));

  assert_store_from_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    storePulse |-> ($past(stepQ) == LAST_STEP));

  assert_step_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    stepQ <= LAST_STEP);

  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(stepQ));

  assert_busy_no_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (storePulse || recallPulse) |-> !$past(busy));

  assert_hold_in_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !$past(chipEnN)) |=> $stable(stepQ));

endmodule

bind seq_unlock_detect sud_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chipEnN    (chipEnN),
  .busy       (busy),
  .storePulse (storePulse),
  .recallPulse(recallPulse),
  .stepQ      (stepQ)
);

// File: tb/sim_seq_unlock_detect.sv
`timescale 1ns/1ps
module sim_seq_unlock_detect;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chipEnN;
  logic        writeEnN;
  logic [12:0] addr;
  logic        busy;
  logic        storePulse;
  logic        recallPulse;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  gotStore;
  bit  gotRecall;
  bit  lastStore;
  bit  lastRecall;

  always #5 clk = ~clk;

  seq_unlock_detect u0 (
    .clk        (clk),
    .rstN       (rstN),
    .chipEnN    (chipEnN),
    .writeEnN   (writeEnN),
    .addr       (addr),
    .busy       (busy),
    .storePulse (storePulse),
    .recallPulse(recallPulse)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One access from a falling edge; leaves on the falling edge where a pulse is due
  task automatic doAccess(logic [12:0] a, bit isWrite);
    chipEnN  = 1'b0;
    addr     = a;
    writeEnN = ~isWrite;
    @(negedge clk);
    chipEnN  = 1'b1;
    writeEnN = 1'b1;
    @(negedge clk);
    lastStore  = storePulse;
    lastRecall = recallPulse;
    gotStore   = gotStore | storePulse;
    gotRecall  = gotRecall | recallPulse;
  endtask

  task automatic clearSeen();
    gotStore  = 1'b0;
    gotRecall = 1'b0;
  endtask

  task automatic leadFive();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0AAA, 1'b0);
    doAccess(13'h1FFF, 1'b0);
    doAccess(13'h10F0, 1'b0);
  endtask

  task automatic testReset();
    check("R1 store after reset", storePulse, 0);
    check("R1 recall after reset", recallPulse, 0);
  endtask

  task automatic testStore();
    clearSeen();
    leadFive();
    check("R2 no early pulse", gotStore | gotRecall, 0);
    doAccess(13'h0F0F, 1'b0);
    check("R2 store pulse due", lastStore, 1);
    check("R9 no recall with store", lastRecall, 0);
    @(negedge clk);
    check("R2 store pulse one clock", storePulse, 0);
  endtask

  task automatic testRecall();
    clearSeen();
    leadFive();
    doAccess(13'h0F0E, 1'b0);
    check("R3 recall pulse due", lastRecall, 1);
    check("R3 no store", gotStore, 0);
    @(negedge clk);
    check("R3 recall pulse one clock", recallPulse, 0);
  endtask

  task automatic testBadFinal();
    clearSeen();
    leadFive();
    doAccess(13'h0F0D, 1'b0);
    doAccess(13'h0F0F, 1'b0);
    check("R4 bad final gives nothing", gotStore | gotRecall, 0);
    clearSeen();
    leadFive();
    doAccess(13'h0F0F, 1'b0);
    check("R4 idle after bad final", lastStore, 1);
  endtask

  task automatic testInterrupt();
    clearSeen();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0123, 1'b0);
    doAccess(13'h0AAA, 1'b0);
    doAccess(13'h1FFF, 1'b0);
    doAccess(13'h10F0, 1'b0);
    doAccess(13'h0F0F, 1'b0);
    check("R5 stray read aborts", gotStore | gotRecall, 0);
  endtask

  task automatic testWrite();
    clearSeen();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0AAA, 1'b1);
    doAccess(13'h1FFF, 1'b0);
    doAccess(13'h10F0, 1'b0);
    doAccess(13'h0F0F, 1'b0);
    check("R6 write of expected addr aborts", gotStore | gotRecall, 0);
    clearSeen();
    leadFive();
    doAccess(13'h0F0E, 1'b1);
    check("R6 write cannot finish", gotStore | gotRecall, 0);
  endtask

  task automatic testRestart();
    clearSeen();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0AAA, 1'b0);
    leadFive();
    doAccess(13'h0F0F, 1'b0);
    check("R7 restart via first key", lastStore, 1);
    clearSeen();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    doAccess(13'h0AAA, 1'b0);
    doAccess(13'h1FFF, 1'b0);
    doAccess(13'h10F0, 1'b0);
    doAccess(13'h0F0E, 1'b0);
    check("R7 restart mid run", lastRecall, 1);
  endtask

  task automatic testBusy();
    clearSeen();
    busy = 1'b1;
    leadFive();
    doAccess(13'h0F0F, 1'b0);
    busy = 1'b0;
    check("R8 busy run gives nothing", gotStore | gotRecall, 0);
    clearSeen();
    doAccess(13'h0000, 1'b0);
    doAccess(13'h1555, 1'b0);
    busy = 1'b1;
    doAccess(13'h0777, 1'b0);
    doAccess(13'h0AAA, 1'b1);
    busy = 1'b0;
    doAccess(13'h0AAA, 1'b0);
    doAccess(13'h1FFF, 1'b0);
    doAccess(13'h10F0, 1'b0);
    doAccess(13'h0F0E, 1'b0);
    check("R8 busy accesses ignored", lastRecall, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    rstN     = 1'b0;
    chipEnN  = 1'b1;
    writeEnN = 1'b1;
    addr     = '0;
    busy     = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStore();
    testRecall();
    testBadFinal();
    testInterrupt();
    testWrite();
    testRestart();
    testBusy();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule